// File: doc/BRIEF.md
# Time-Base Bit-Select Interval Timer

This block watches a free-running 64-bit time-base value and raises two kinds of periodic event: a fixed-interval event and a watchdog event. An event occurs when one chosen time-base bit goes from 0 to 1. A 32-bit control word chooses that bit for each event, so the interval is a power of two of time-base ticks rather than a loaded count. A third event source, the decrementer, arrives as a one-cycle input pulse from a neighbouring block.

Each event sets its own sticky bit in a 32-bit status word. Software clears these bits by writing ones to the status word. Each interrupt line is a level that is high while its status bit and its enable bit in the control word are both set. The bit-select rule is chosen by a parameter. In the extended rule, a 2-bit period field joined with a 4-bit extension field gives the bit index. In the table rule, only the 2-bit field is used, and it indexes four parameter entries.

Top module: `tbsel_interval_timer`

## Requirements
- R1: After reset, the control readback and the status readback are zero and all three interrupt lines are low. A selected bit must be seen at 0 after reset before it can produce an event.
- R2: A control write stores the full 32-bit word, and the control readback returns it on the next cycle. The fields are: watchdog period at bits 31:30, watchdog interrupt enable at bit 27, decrementer interrupt enable at bit 26, fixed-interval period at bits 25:24, fixed-interval interrupt enable at bit 23, watchdog extension at bits 20:17, and fixed-interval extension at bits 16:13.
- R3: With EXT_MODE=1, the selected bit index (LSB = 0) is 63 − ({ext, period}), that is, 63 − (period | ext<<2).
- R4: With EXT_MODE=0, period value k selects entry k of the 6-bit-per-entry table parameter. Entry 0 is at bits 5:0.
- R5: A 0-to-1 change of the fixed-interval bit sets status bit 26. A 1-to-0 change, a bit that stays high, or a change on any other bit does not set it.
- R6: A 0-to-1 change of the watchdog bit sets status bit 30.
- R7: A pulse on `dec_hit` sets status bit 27.
- R8: A status write clears each status bit written as 1 and leaves every other bit unchanged.
- R9: If an event and a clear of the same status bit happen in the same cycle, the event wins and the bit stays set.
- R10: `irq_fix`, `irq_wdg` and `irq_dec` are each high exactly when status bit 26/30/27 and enable bit 23/27/26 are both set.
- R11: A control write re-primes both edge detectors from the newly selected bits. No event comes from the write cycle itself, and none comes from the change of selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbase | input | 64 | Time-base value |
| dec_hit | input | 1 | Decrementer event pulse |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control write data |
| sts_wr | input | 1 | Status write-one-to-clear strobe |
| sts_wdata | input | 32 | Status clear mask |
| ctl_rdata | output | 32 | Control readback |
| sts_rdata | output | 32 | Status readback |
| irq_fix | output | 1 | Fixed-interval interrupt |
| irq_wdg | output | 1 | Watchdog interrupt |
| irq_dec | output | 1 | Decrementer interrupt |

## Verification
The bench builds two copies of the block that share one set of inputs. The first uses EXT_MODE=1, so selected indices such as 54 and 41 can be reached through the period and extension fields. The second uses EXT_MODE=0 with the table entries overridden to small indices (fixed 3/5/7/9, watchdog 10/12/14/16), so table lookup can be told apart from the extended formula. The bench drives the time base directly instead of counting it. This lets it place a rising edge on any chosen bit, at the same moment as a control write or a status clear.

// File: rtl/tbsel_interval_timer.sv
module tbsel_interval_timer #(
  parameter bit          EXT_MODE  = 1'b1,
  parameter logic [23:0] FIX_TABLE = {6'd9, 6'd13, 6'd17, 6'd21},
  parameter logic [23:0] WDG_TABLE = {6'd21, 6'd25, 6'd29, 6'd33}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] tbase,
  input  logic        dec_hit,
  input  logic        ctl_wr,
  input  logic [31:0] ctl_wdata,
  input  logic        sts_wr,
  input  logic [31:0] sts_wdata,
  output logic [31:0] ctl_rdata,
  output logic [31:0] sts_rdata,
  output logic        irq_fix,
  output logic        irq_wdg,
  output logic        irq_dec
);
  localparam int FIX_STS = 26;
  localparam int DEC_STS = 27;
  localparam int WDG_STS = 30;

  logic [31:0] ctl_q, sts_q, set_vec, clr_vec;
  logic        prev_fix, prev_wdg;
  logic [5:0]  fix_sel, wdg_sel, fix_sel_nx, wdg_sel_nx;
  logic        fix_evt, wdg_evt;

  function automatic logic [5:0] pick(input logic [1:0] per, input logic [3:0] ext,
                                      input logic [23:0] tbl);
    if (EXT_MODE) return 6'd63 - {ext, per};
    case (per)
      2'd0:    return tbl[5:0];
      2'd1:    return tbl[11:6];
      2'd2:    return tbl[17:12];
      default: return tbl[23:18];
    endcase
  endfunction

  assign fix_sel    = pick(ctl_q[25:24], ctl_q[16:13], FIX_TABLE);
  assign wdg_sel    = pick(ctl_q[31:30], ctl_q[20:17], WDG_TABLE);
  assign fix_sel_nx = pick(ctl_wdata[25:24], ctl_wdata[16:13], FIX_TABLE);
  assign wdg_sel_nx = pick(ctl_wdata[31:30], ctl_wdata[20:17], WDG_TABLE);

  assign fix_evt = !ctl_wr && !prev_fix && tbase[fix_sel];
  assign wdg_evt = !ctl_wr && !prev_wdg && tbase[wdg_sel];

  always_comb begin
    set_vec = '0;
    set_vec[FIX_STS] = fix_evt;
    set_vec[WDG_STS] = wdg_evt;
    set_vec[DEC_STS] = dec_hit;
  end
  assign clr_vec = sts_wr ? sts_wdata : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      sts_q    <= '0;
      prev_fix <= 1'b1;
      prev_wdg <= 1'b1;
    end else begin
      sts_q <= (sts_q & ~clr_vec) | set_vec;
      if (ctl_wr) begin
        ctl_q    <= ctl_wdata;
        prev_fix <= tbase[fix_sel_nx];
        prev_wdg <= tbase[wdg_sel_nx];
      end else begin
        prev_fix <= tbase[fix_sel];
        prev_wdg <= tbase[wdg_sel];
      end
    end
  end

  assign ctl_rdata = ctl_q;
  assign sts_rdata = sts_q;
  assign irq_fix   = sts_q[FIX_STS] & ctl_q[23];
  assign irq_wdg   = sts_q[WDG_STS] & ctl_q[27];
  assign irq_dec   = sts_q[DEC_STS] & ctl_q[26];

  AST_FIX_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[FIX_STS]) |-> $past(fix_evt)); // R5
  AST_WDG_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[WDG_STS]) |-> $past(wdg_evt)); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && sts_wdata[DEC_STS] && !dec_hit) |=> !sts_q[DEC_STS]); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_evt && sts_wr && sts_wdata[FIX_STS]) |=> sts_q[FIX_STS]); // R9
  AST_CTL_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !$rose(sts_q[FIX_STS]) && !$rose(sts_q[WDG_STS])); // R11
  AST_IRQ_NEEDS_STS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_fix || irq_wdg || irq_dec) |-> (sts_rdata != 32'd0)); // R10
endmodule

// File: tb/tbsel_interval_timer_tb.sv
module tbsel_interval_timer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [63:0] tb = '0;
  logic dec_hit = 1'b0, ctl_wr = 1'b0, sts_wr = 1'b0;
  logic [31:0] ctl_wdata = '0, sts_wdata = '0;
  logic [31:0] e_ctl, e_sts, t_ctl, t_sts;
  logic e_if, e_iw, e_id, t_if, t_iw, t_id;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tbsel_interval_timer #(.EXT_MODE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .tbase(tb), .dec_hit(dec_hit), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .ctl_rdata(e_ctl), .sts_rdata(e_sts), .irq_fix(e_if), .irq_wdg(e_iw), .irq_dec(e_id));

  tbsel_interval_timer #(.EXT_MODE(1'b0),
    .FIX_TABLE({6'd9, 6'd7, 6'd5, 6'd3}), .WDG_TABLE({6'd16, 6'd14, 6'd12, 6'd10})) dut_tab_i (
    .clk(clk), .rst_n(rst_n), .tbase(tb), .dec_hit(dec_hit), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .ctl_rdata(t_ctl), .sts_rdata(t_sts), .irq_fix(t_if), .irq_wdg(t_iw), .irq_dec(t_id));

  function automatic int ext_bit(input int per, input int ext);
    return 63 - (per | (ext << 2));
  endfunction

  function automatic logic [31:0] ctlw(input int wp, input int wx, input int fp, input int fx,
                                       input bit wie, input bit die, input bit fie);
    logic [31:0] v = '0;
    v[31:30] = wp[1:0]; v[20:17] = wx[3:0]; v[25:24] = fp[1:0]; v[16:13] = fx[3:0];
    v[27] = wie; v[26] = die; v[23] = fie;
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic wr_ctl(input logic [31:0] v);
    ctl_wr = 1'b1; ctl_wdata = v; tick(); ctl_wr = 1'b0;
  endtask
  task automatic wr_sts(input logic [31:0] v);
    sts_wr = 1'b1; sts_wdata = v; tick(); sts_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ext ctl", e_ctl, 0); chk("R1 ext sts", e_sts, 0);
    chk("R1 tab sts", t_sts, 0);
    chk("R1 irqs", {26'd0, e_if, e_iw, e_id, t_if, t_iw, t_id}, 0);
  endtask

  task automatic t_ctl_rb();
    wr_ctl(32'hA5C3_1E7F);
    chk("R2 readback", e_ctl, 32'hA5C3_1E7F);
    wr_ctl(0); chk("R2 readback zero", t_ctl, 0);
    wr_sts('1);
  endtask

  task automatic t_ext_fix();
    int b = ext_bit(1, 2);
    tb = '0; wr_ctl(ctlw(0, 0, 1, 2, 0, 0, 0)); wr_sts('1);
    tb[b-1] = 1'b1; tick(); chk("R5 other bit no event", e_sts[26], 0);
    tb[b] = 1'b1; tick(); chk("R3 R5 rise on bit 54", e_sts[26], 1);
    wr_sts('1); tick(); chk("R5 steady high no event", e_sts[26], 0);
    tb[b] = 1'b0; tick(); chk("R5 falling no event", e_sts[26], 0);
  endtask

  task automatic t_ext_wdg();
    int b = ext_bit(2, 5);
    tb = '0; wr_ctl(ctlw(2, 5, 0, 0, 0, 0, 0)); wr_sts('1);
    tb[b] = 1'b1; tick();
    chk("R3 R6 watchdog rise on bit 41", e_sts, 32'h4000_0000);
  endtask

  task automatic t_table();
    tb = '0; wr_ctl(ctlw(3, 0, 2, 0, 0, 0, 0)); wr_sts('1);
    tb[7] = 1'b1; tb[16] = 1'b1; tick();
    chk("R4 table fix+wdg", t_sts, 32'h4400_0000);
    chk("R4 ext copy unaffected", e_sts, 0);
  endtask

  task automatic t_dec();
    wr_sts('1);
    dec_hit = 1'b1; tick(); dec_hit = 1'b0;
    chk("R7 dec status", e_sts, 32'h0800_0000);
  endtask

  task automatic t_w1c();
    tb = '0; wr_ctl(ctlw(3, 0, 2, 0, 0, 0, 0)); wr_sts('1);
    tb[7] = 1'b1; tb[16] = 1'b1; dec_hit = 1'b1; tick(); dec_hit = 1'b0;
    chk("R8 all set", t_sts, 32'h4C00_0000);
    wr_sts(32'h0400_0000); chk("R8 clear fix only", t_sts, 32'h4800_0000);
    wr_sts(32'h4000_0000); chk("R8 clear wdg only", t_sts, 32'h0800_0000);
    wr_sts(32'h0); chk("R8 zero write no change", t_sts, 32'h0800_0000);
  endtask

  task automatic t_irq();
    tb[7] = 1'b0; tick(); tb[7] = 1'b1; tick();
    wr_ctl(ctlw(3, 0, 2, 0, 0, 0, 1));
    chk("R10 fix irq only", {29'd0, t_if, t_iw, t_id}, 3'b100);
    wr_ctl(ctlw(3, 0, 2, 0, 1, 1, 0));
    chk("R10 dec irq only", {29'd0, t_if, t_iw, t_id}, 3'b001);
  endtask

  task automatic t_set_wins();
    int b = ext_bit(1, 2);
    tb = '0; wr_ctl(ctlw(0, 0, 1, 2, 0, 0, 0)); wr_sts('1);
    tb[b] = 1'b1; sts_wr = 1'b1; sts_wdata = 32'h0400_0000; tick(); sts_wr = 1'b0;
    chk("R9 event beats clear", e_sts[26], 1);
  endtask

  task automatic t_reprime();
    int b = ext_bit(1, 2);
    tb = '0; wr_ctl(0); wr_sts('1);
    tb[b] = 1'b1; tick();
    wr_ctl(ctlw(0, 0, 1, 2, 0, 0, 0)); tick();
    chk("R11 reselect onto high bit no event", e_sts[26], 0);
    tb[b] = 1'b0; tick();
    tb[b] = 1'b1; wr_ctl(ctlw(0, 0, 1, 2, 0, 0, 0)); tick();
    chk("R11 rise during write no event", e_sts[26], 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    rst_n = 1'b1; tick(); tick();
    t_reset();
    t_ctl_rb(); t_ext_fix(); t_ext_wdg(); t_table(); t_dec();
    t_w1c(); t_irq(); t_set_wins(); t_reprime();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1; checks++; fails++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule